// File: doc/BRIEF.md
# Performance Counter Register Bank

This block is the machine-level store for a core's performance monitoring counters and their event selectors. It is reached through a single-cycle control-register port: a 12-bit register address, a write strobe and write data of the core's register width (a parameter, 32 or 64). Counter slots 3 through 31 are always present. Each slot holds a 64-bit counter and an event selector as wide as the register width.

The counters do not count anything on their own. A counter changes only when software writes it, and any written value is accepted. A 32-bit writable mask, supplied by the surrounding platform, makes individual counters read-only while keeping them visible. A set of read-only user-mode alias addresses returns the same counter contents. Read data is combinational from the current address, so a read in the cycle after a write returns the value that was stored. For a masked counter that is the old value.

Top module: `perf_counter_bank`

## Requirements
- R1: Address index fields 0, 1 and 2 (address bits [4:0]) are not decoded in any of the bank's address groups: `csr_hit` is 0 and `csr_rdata` is 0. Slots 3 to 31 all respond.
- R2: Counter low words are at 0xB03–0xB1F, and the slot is address bits [4:0]. With a 64-bit register width, one access reads and writes all 64 counter bits.
- R3: Counter high words are at 0xB83–0xB9F and are decoded only at a 32-bit register width. At that width the low address reaches bits [31:0] and the high address reaches bits [63:32].
- R4: Event selectors are at 0x323–0x33F, indexed by address bits [4:0], and are read/write at full register width. The writable mask does not apply to them.
- R5: User aliases at 0xC03–0xC1F return the counter low word. At a 32-bit width, the aliases at 0xC83–0xC9F return the counter high word.
- R6: A write to a user alias address changes no counter and no event selector.
- R7: Counters and event selectors keep their value in every cycle without a write to them.
- R8: A counter write takes effect only when `wen_mask` bit [slot] is 1. Otherwise the counter keeps its old value, and the following read returns that old value.
- R9: After reset every counter and every event selector reads 0.
- R10: Any address outside the groups above gives `csr_hit` = 0 and `csr_rdata` = 0.
- R11: A write on one clock edge is visible on `csr_rdata` in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write strobe for the addressed register |
| csr_wdata | input | XLEN | Write data |
| wen_mask | input | 32 | Per-slot counter write enable (bit n controls slot n) |
| csr_hit | output | 1 | Address belongs to this bank |
| csr_rdata | output | XLEN | Read data of the addressed register, 0 on a miss |

## Verification
The assertions assume that `wen_mask` and `csr_we` are steady from one clock edge to the next and change only between edges. The stability checks in each slot rely on this. The stimulus drives every input on the falling edge and holds `csr_we` high for exactly one rising edge per write. It reads only after the write strobe has dropped. It changes the mask only while no write is in flight, so every write sees a settled enable.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_EVT,
    K_MLO,
    K_MHI,
    K_ULO,
    K_UHI
  } pcb_kind_e;

  // Address bits [11:5] of each register group.
  localparam logic [6:0] GRP_EVT = 7'b0011001;
  localparam logic [6:0] GRP_MLO = 7'b1011000;
  localparam logic [6:0] GRP_MHI = 7'b1011100;
  localparam logic [6:0] GRP_ULO = 7'b1100000;
  localparam logic [6:0] GRP_UHI = 7'b1100100;

endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CNT_W     = 64,
  parameter int FIRST_IDX = 3
) (
  input  logic [11:0] addr,
  output pcb_kind_e   kind,
  output logic [4:0]  idx
);

  localparam bit HAS_HI = (XLEN < CNT_W);

  logic in_range;

  always_comb begin
    idx      = addr[4:0];
    in_range = (addr[4:0] >= 5'(FIRST_IDX));
    kind     = K_NONE;
    if (in_range) begin
      unique case (addr[11:5])
        GRP_EVT: kind = K_EVT;
        GRP_MLO: kind = K_MLO;
        GRP_MHI: kind = HAS_HI ? K_MHI : K_NONE;
        GRP_ULO: kind = K_ULO;
        GRP_UHI: kind = HAS_HI ? K_UHI : K_NONE;
        default: kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pcb_slot.sv
module pcb_slot #(
  parameter int XLEN  = 32,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic             we_evt,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [XLEN-1:0]  evt
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [XLEN-1:0]  evt_q;
  logic             cnt_en;

  assign cnt_en = we_lo | we_hi;

  generate
    if (XLEN >= CNT_W) begin : g_wide
      always_comb begin
        cnt_nxt = cnt_q;
        if (we_lo) cnt_nxt = wdata[CNT_W-1:0];
      end
    end else begin : g_split
      always_comb begin
        cnt_nxt = cnt_q;
        if (we_lo) cnt_nxt[XLEN-1:0]     = wdata;
        if (we_hi) cnt_nxt[CNT_W-1:XLEN] = wdata[CNT_W-XLEN-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (we_evt) evt_q <= wdata;
  end

  assign cnt = cnt_q;
  assign evt = evt_q;

  // R7: without a write the counter does not advance
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_lo || we_hi) |=> $stable(cnt_q));

  // R7: without a write the event selector does not change
  a_r7_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_evt |=> $stable(evt_q));

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CNT_W     = 64,
  parameter int FIRST_IDX = 3,
  parameter int LAST_IDX  = 31,
  parameter int MASK_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       csr_addr,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [MASK_W-1:0] wen_mask,
  output logic              csr_hit,
  output logic [XLEN-1:0]   csr_rdata
);

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pcb_kind_e  kind;
  logic [4:0] idx;

  pcb_decode #(
    .XLEN      (XLEN),
    .CNT_W     (CNT_W),
    .FIRST_IDX (FIRST_IDX)
  ) u_decode (
    .addr (csr_addr),
    .kind (kind),
    .idx  (idx)
  );

  logic [CNT_W-1:0] cnt_arr [FIRST_IDX:LAST_IDX];
  logic [XLEN-1:0]  evt_arr [FIRST_IDX:LAST_IDX];

  logic [FIRST_IDX-1:0] unused_mask_low;
  assign unused_mask_low = wen_mask[FIRST_IDX-1:0];

  generate
    for (genvar i = FIRST_IDX; i <= LAST_IDX; i++) begin : g_slot
      logic sel, we_lo, we_hi, we_evt;

      assign sel    = csr_we && (idx == 5'(i));
      assign we_lo  = sel && (kind == K_MLO) && wen_mask[i];
      assign we_hi  = sel && (kind == K_MHI) && wen_mask[i];
      assign we_evt = sel && (kind == K_EVT);

      pcb_slot #(
        .XLEN  (XLEN),
        .CNT_W (CNT_W)
      ) u_slot (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .we_lo  (we_lo),
        .we_hi  (we_hi),
        .we_evt (we_evt),
        .wdata  (csr_wdata),
        .cnt    (cnt_arr[i]),
        .evt    (evt_arr[i])
      );

      // R8: a write with the slot's mask bit clear leaves the counter alone
      a_r8_ro_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
        (csr_we && !wen_mask[i]) |=> $stable(cnt_arr[i]));

      // R6: writes to user alias addresses change nothing in the slot
      a_r6_alias_nowrite: assert property (@(posedge clk) disable iff (!rst_int_n)
        (csr_we && (csr_addr[11:10] == 2'b11)) |=> ($stable(cnt_arr[i]) && $stable(evt_arr[i])));
    end
  endgenerate

  // Read path
  logic [CNT_W-1:0] sel_cnt;
  logic [XLEN-1:0]  sel_evt;

  always_comb begin
    sel_cnt = '0;
    sel_evt = '0;
    for (int i = FIRST_IDX; i <= LAST_IDX; i++) begin
      if (idx == 5'(i)) begin
        sel_cnt = cnt_arr[i];
        sel_evt = evt_arr[i];
      end
    end
  end

  always_comb begin
    csr_hit = (kind != K_NONE);
    unique case (kind)
      K_EVT:        csr_rdata = sel_evt;
      K_MLO, K_ULO: csr_rdata = sel_cnt[XLEN-1:0];
      K_MHI, K_UHI: csr_rdata = XLEN'(sel_cnt >> XLEN);
      default:      csr_rdata = '0;
    endcase
  end

  // R1: index fields below the first slot never hit
  always_comb begin
    a_r1_low_idx_miss: assert (!csr_hit || (csr_addr[4:0] >= 5'(FIRST_IDX)));
  end

  // R10: a miss reads as zero
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !csr_hit |-> (csr_rdata == '0));

endmodule

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        we;
  logic [63:0] wdata;
  logic [31:0] mask;
  logic        hit32, hit64;
  logic [31:0] rd32;
  logic [63:0] rd64;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [63:0] m32 [32];
  logic [31:0] e32 [32];
  logic [63:0] m64 [32];
  logic [63:0] e64 [32];

  always #4 clk = ~clk;

  perf_counter_bank #(.XLEN(32)) u_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we),
    .csr_wdata(wdata[31:0]), .wen_mask(mask),
    .csr_hit(hit32), .csr_rdata(rd32)
  );

  perf_counter_bank #(.XLEN(64)) u_perf_counter_bank_w64 (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we),
    .csr_wdata(wdata), .wen_mask(mask),
    .csr_hit(hit64), .csr_rdata(rd64)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Write, and update the model from the requirements.
  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    logic [4:0] ix;
    ix = a[4:0];
    if (ix >= 5'd3) begin
      case (a[11:5])
        7'h19: begin e32[ix] = d[31:0]; e64[ix] = d; end
        7'h58: if (mask[ix]) begin m32[ix][31:0] = d[31:0]; m64[ix] = d; end
        7'h5C: if (mask[ix]) m32[ix][63:32] = d[31:0];
        default: ;
      endcase
    end
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // Read both instances and compare against the model.
  task automatic rd(input string req, input logic [11:0] a);
    logic [4:0]  ix;
    logic        h32, h64;
    logic [63:0] x32, x64;
    ix = a[4:0];
    h32 = 0; h64 = 0; x32 = '0; x64 = '0;
    if (ix >= 5'd3) begin
      case (a[11:5])
        7'h19:        begin h32 = 1; h64 = 1; x32 = {32'b0, e32[ix]}; x64 = e64[ix]; end
        7'h58, 7'h60: begin h32 = 1; h64 = 1; x32 = {32'b0, m32[ix][31:0]}; x64 = m64[ix]; end
        7'h5C, 7'h64: begin h32 = 1; x32 = {32'b0, m32[ix][63:32]}; end
        default: ;
      endcase
    end
    @(negedge clk);
    addr = a;
    #1;
    chk(req, $sformatf("w32 rdata @%h", a), {32'b0, rd32}, x32);
    chk(req, $sformatf("w32 hit @%h", a), {63'b0, hit32}, {63'b0, h32});
    chk(req, $sformatf("w64 rdata @%h", a), rd64, x64);
    chk(req, $sformatf("w64 hit @%h", a), {63'b0, hit64}, {63'b0, h64});
  endtask

  function automatic logic [63:0] pat(input int i, input int seed);
    return {32'(seed) * 32'h9E37_79B9 ^ 32'(i) * 32'h0101_0101,
            32'(i) * 32'h1357_9BDF + 32'(seed)};
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m32[i] = '0; e32[i] = '0; m64[i] = '0; e64[i] = '0;
    end
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; mask = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state of every slot
    for (int i = 3; i < 32; i++) begin
      rd("R9", 12'hB00 | 12'(i));
      rd("R9", 12'hB80 | 12'(i));
      rd("R9", 12'h320 | 12'(i));
    end

    // R2 R3 R4 R11: fill all slots, read back through machine addresses
    for (int i = 3; i < 32; i++) begin
      wr(12'hB00 | 12'(i), pat(i, 1));
      rd("R11", 12'hB00 | 12'(i));
      wr(12'hB80 | 12'(i), pat(i, 2));
      wr(12'h320 | 12'(i), pat(i, 3));
    end
    for (int i = 3; i < 32; i++) begin
      rd("R2", 12'hB00 | 12'(i));
      rd("R3", 12'hB80 | 12'(i));
      rd("R4", 12'h320 | 12'(i));
      rd("R5", 12'hC00 | 12'(i));
      rd("R5", 12'hC80 | 12'(i));
    end

    // R3: high-half write leaves low half intact (model keeps low)
    wr(12'hB8A, 64'hFFFF_FFFF_DEAD_BEEF);
    rd("R3", 12'hB0A);
    rd("R3", 12'hB8A);

    // R7: idle cycles do not advance anything
    repeat (60) @(negedge clk);
    for (int i = 3; i < 32; i += 7) begin
      rd("R7", 12'hB00 | 12'(i));
      rd("R7", 12'h320 | 12'(i));
    end

    // R8: read-only slots 7 and 20
    @(negedge clk);
    mask = 32'hFFFF_FFFF ^ (32'h1 << 7) ^ (32'h1 << 20);
    for (int i = 3; i < 32; i++) begin
      wr(12'hB00 | 12'(i), pat(i, 5));
      wr(12'hB80 | 12'(i), pat(i, 6));
    end
    for (int i = 3; i < 32; i++) begin
      rd("R8", 12'hB00 | 12'(i));
      rd("R8", 12'hB80 | 12'(i));
    end
    // R4: event selectors ignore the mask
    wr(12'h327, 64'h0123_4567_89AB_CDEF);
    rd("R4", 12'h327);
    wr(12'h334, 64'h5555_AAAA_1234_5678);
    rd("R4", 12'h334);

    // R6: writes to user aliases are ignored
    @(negedge clk);
    mask = 32'hFFFF_FFFF;
    wr(12'hC05, 64'hBAD0_BAD0_BAD0_BAD0);
    wr(12'hC85, 64'hBAD1_BAD1_BAD1_BAD1);
    wr(12'hC1F, 64'hBAD2_BAD2_BAD2_BAD2);
    rd("R6", 12'hB05);
    rd("R6", 12'hB85);
    rd("R6", 12'hB1F);
    rd("R6", 12'h325);

    // R1 R10: undecoded index fields and foreign addresses
    for (int i = 0; i < 3; i++) begin
      rd("R1", 12'hB00 | 12'(i));
      rd("R1", 12'hB80 | 12'(i));
      rd("R1", 12'h320 | 12'(i));
      rd("R1", 12'hC00 | 12'(i));
      wr(12'hB00 | 12'(i), 64'hFFFF_FFFF_FFFF_FFFF);
    end
    rd("R1", 12'hB03);
    rd("R10", 12'h7A0);
    rd("R10", 12'h340);
    rd("R10", 12'hB40);
    rd("R10", 12'hD03);
    rd("R10", 12'h000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule